// File: doc/BRIEF.md
# Pillar Point Feature Generator

This block turns the points of one occupied pillar of a bird's-eye-view grid into per-point feature rows for a downstream point-wise convolution stage. A pillar is announced on a small command stream that carries its point count (1 to 16) and its grid column and row. The block then reads the pillar's points twice from an external point store. The first pass sums x, y and z. A single shared reciprocal multiplier then turns each sum into a mean, one axis per cycle. The second pass emits one 9-element row of 16-bit signed values for every one of the 16 row slots of the pillar.

The rows land in one bank of a two-bank feature buffer. The consumer works on the other bank meanwhile, so feature generation for one pillar overlaps the convolution of the previous one. A bank becomes the consumer's when the block finishes filling it. The consumer gives it back with a release pulse. The block never starts a pillar into a bank that the consumer has not yet released.

The command input is valid/ready. A pillar is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. The sender keeps `cmd_valid` and the command fields steady until that cycle. `cmd_ready` stays low while a pillar is in flight, and also while the bank due to be filled next is still held by the consumer. This is the only back-pressure point. The point read port and the feature write port are plain strobes with fixed timing and carry no stall.

Top module: `pillar_feat_unit`

## Requirements
- R1: `cmd_ready` is high only while no pillar is in flight and the next bank is free. A command with count 1..16 is taken on the cycle where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is low on the following cycle.
- R2: For each pillar the block pulses `rd_en` exactly 2×count times. All addresses are below count, issued 0 upward in each pass. `rd_data` is expected one cycle after `rd_en`, with x in bits 15:0, y in 31:16, z in 47:32 and r in 63:48, each signed 16-bit.
- R3: Each feature row holds nine 16-bit slots, slot k at bits 16k+15:16k, in this order: x, y, z, r, x−mean_x, y−mean_y, z−mean_z, x−center_x, y−center_y.
- R4: mean_a equals the sum of axis a over the pillar's points divided by the count, rounded to nearest with ties going away from zero.
- R5: center_x = column×32+16 and center_y = row×32+16.
- R6: The five difference slots saturate to the range −32768..32767.
- R7: Every pillar writes all 16 rows, row 0 upward, on consecutive cycles. Rows at index count and above are written as all zeros.
- R8: Pillars fill bank 0 first and then alternate banks. `cons_valid` rises when a bank is complete. `cons_bank` starts at 0 and flips on each accepted release.
- R9: While the consumer holds the bank due next, `cmd_ready` stays low. A release of that bank raises `cmd_ready` again. No write ever targets the bank the consumer holds.
- R10: A `cons_release` pulse while `cons_valid` is low has no effect.
- R11: After reset `cmd_ready` is 1, and `cons_valid`, `cons_bank`, `rd_en` and `fb_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Pillar command valid |
| cmd_ready | output | 1 | Block can take a pillar |
| cmd_count | input | 5 | Points in the pillar, 1..16 |
| cmd_gx | input | 7 | Pillar grid column |
| cmd_gy | input | 7 | Pillar grid row |
| rd_en | output | 1 | Point read strobe |
| rd_addr | output | 4 | Point index within the pillar |
| rd_data | input | 64 | Point returned one cycle after the strobe |
| fb_we | output | 1 | Feature row write strobe |
| fb_bank | output | 1 | Bank being written |
| fb_row | output | 4 | Row being written |
| fb_data | output | 144 | Nine 16-bit feature slots |
| cons_valid | output | 1 | Consumer's bank holds a finished pillar |
| cons_bank | output | 1 | Bank the consumer reads |
| cons_release | input | 1 | Consumer gives its bank back |

## Verification
The embedded properties assume a well-behaved environment. The sender holds `cmd_valid` until it is taken and never offers a count of 0 or more than 16. The point store answers exactly one cycle after each strobe, and its contents do not change while a pillar is in flight, since the second pass re-reads the same points. The stimulus meets these assumptions. Its driver offers a command only after loading the store, and it does not touch the store again until the scoreboard has drained every row expected for that pillar. Releases are issued only at chosen points between pillars. The one exception is a deliberate release with no held bank, which exercises R10.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
  localparam int NUM_AXES = 3;
  localparam int NUM_FEAT = 9;
  // slot positions inside one feature row (consumer decodes them)
  localparam int F_X  = 0;
  localparam int F_Y  = 1;
  localparam int F_Z  = 2;
  localparam int F_R  = 3;
  localparam int F_DX = 4;
  localparam int F_DY = 5;
  localparam int F_DZ = 6;
  localparam int F_CX = 7;
  localparam int F_CY = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC,
    ST_ACC_WAIT,
    ST_DIV,
    ST_OFS,
    ST_OFS_LAST
  } pfu_state_e;
endpackage

// File: rtl/pfu_accum.sv
module pfu_accum import pfu_pkg::*; #(
  parameter int COORD_W = 16,
  parameter int SUM_W   = 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          en,
  input  logic [NUM_AXES*COORD_W-1:0]   xyz,
  output logic [NUM_AXES*SUM_W-1:0]     sums
);
  for (genvar a = 0; a < NUM_AXES; a++) begin : g_ax
    logic signed [COORD_W-1:0] v;
    logic signed [SUM_W-1:0]   acc;
    assign v = xyz[a*COORD_W +: COORD_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc <= '0;
      else if (clr)  acc <= '0;
      else if (en)   acc <= acc + SUM_W'(v);
    end
    assign sums[a*SUM_W +: SUM_W] = acc;
  end
endmodule

// File: rtl/pfu_mean_div.sv
module pfu_mean_div import pfu_pkg::*; #(
  parameter int COORD_W = 16,
  parameter int MAX_PTS = 16,
  parameter int CNT_W   = 5,
  parameter int IDX_W   = 4,
  parameter int SUM_W   = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [CNT_W-1:0]            count,
  input  logic [NUM_AXES*SUM_W-1:0]   sums,
  output logic [NUM_AXES*COORD_W-1:0] means,
  output logic                        done
);
  localparam int T_W = SUM_W + 1;
  localparam int F   = SUM_W + CNT_W + 3;
  localparam int P_W = T_W + F;

  // ceil(2^F / (2n)) for n = 1..MAX_PTS
  logic [F-1:0] recip [MAX_PTS];
  for (genvar i = 0; i < MAX_PTS; i++) begin : g_rc
    assign recip[i] = F'(((64'd1 << F) + 64'(2*(i+1)) - 64'd1) / 64'(2*(i+1)));
  end

  logic                     busy;
  logic [1:0]               ax;
  logic signed [SUM_W-1:0]  s_sel;
  logic [SUM_W-1:0]         mag;
  logic [T_W-1:0]           t;
  logic [P_W-1:0]           prod;
  logic [COORD_W:0]         q;
  logic [COORD_W-1:0]       m;
  logic [IDX_W-1:0]         ridx;

  always_comb begin
    ridx  = IDX_W'(count - 1'b1);
    s_sel = sums[ax*SUM_W +: SUM_W];
    mag   = s_sel[SUM_W-1] ? SUM_W'(-s_sel) : SUM_W'(s_sel);
    t     = {mag, 1'b0} + T_W'(count);           // 2|s| + n, divided by 2n
    prod  = P_W'(t) * P_W'(recip[ridx]);
    q     = (COORD_W+1)'(prod >> F);
    m     = s_sel[SUM_W-1] ? COORD_W'(-q) : COORD_W'(q);
  end

  assign done = busy && (ax == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ax    <= '0;
      means <= '0;
    end else if (start) begin
      busy <= 1'b1;
      ax   <= '0;
    end else if (busy) begin
      means[ax*COORD_W +: COORD_W] <= m;
      if (ax == 2'd2) busy <= 1'b0;
      ax <= ax + 1'b1;
    end
  end

  AST_DIV_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R4
endmodule

// File: rtl/pfu_feat.sv
module pfu_feat import pfu_pkg::*; #(
  parameter int COORD_W = 16,
  parameter int CTR_W   = 12
) (
  input  logic                        live,
  input  logic [4*COORD_W-1:0]        point,
  input  logic [NUM_AXES*COORD_W-1:0] means,
  input  logic [CTR_W-1:0]            cx,
  input  logic [CTR_W-1:0]            cy,
  output logic [NUM_FEAT*COORD_W-1:0] feat
);
  localparam int D_W = COORD_W + 2;
  localparam logic signed [D_W-1:0] D_HI = {3'b000, {(COORD_W-1){1'b1}}};
  localparam logic signed [D_W-1:0] D_LO = {3'b111, {(COORD_W-1){1'b0}}};

  function automatic logic signed [D_W-1:0] sx(input logic [COORD_W-1:0] v);
    return D_W'($signed(v));
  endfunction

  function automatic logic signed [D_W-1:0] zx(input logic [CTR_W-1:0] v);
    return $signed(D_W'(v));
  endfunction

  function automatic logic [COORD_W-1:0] sat(input logic signed [D_W-1:0] d);
    if (d > D_HI)      return D_HI[COORD_W-1:0];
    else if (d < D_LO) return D_LO[COORD_W-1:0];
    else               return d[COORD_W-1:0];
  endfunction

  logic [COORD_W-1:0] px, py, pz, pr, mx, my, mz;

  always_comb begin
    px = point[0*COORD_W +: COORD_W];
    py = point[1*COORD_W +: COORD_W];
    pz = point[2*COORD_W +: COORD_W];
    pr = point[3*COORD_W +: COORD_W];
    mx = means[0*COORD_W +: COORD_W];
    my = means[1*COORD_W +: COORD_W];
    mz = means[2*COORD_W +: COORD_W];
    feat = '0;
    if (live) begin
      feat[F_X*COORD_W  +: COORD_W] = px;
      feat[F_Y*COORD_W  +: COORD_W] = py;
      feat[F_Z*COORD_W  +: COORD_W] = pz;
      feat[F_R*COORD_W  +: COORD_W] = pr;
      feat[F_DX*COORD_W +: COORD_W] = sat(sx(px) - sx(mx));
      feat[F_DY*COORD_W +: COORD_W] = sat(sx(py) - sx(my));
      feat[F_DZ*COORD_W +: COORD_W] = sat(sx(pz) - sx(mz));
      feat[F_CX*COORD_W +: COORD_W] = sat(sx(px) - zx(cx));
      feat[F_CY*COORD_W +: COORD_W] = sat(sx(py) - zx(cy));
    end
  end
endmodule

// File: rtl/pfu_pingpong.sv
module pfu_pingpong (
  input  logic clk,
  input  logic rst_n,
  input  logic prod_done,
  input  logic cons_release,
  output logic prod_bank,
  output logic prod_free,
  output logic cons_bank,
  output logic cons_valid
);
  logic [1:0] full;

  assign prod_free  = !full[prod_bank];
  assign cons_valid = full[cons_bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= '0;
      prod_bank <= 1'b0;
      cons_bank <= 1'b0;
    end else begin
      if (prod_done) begin
        full[prod_bank] <= 1'b1;
        prod_bank       <= ~prod_bank;
      end
      if (cons_release && full[cons_bank]) begin
        full[cons_bank] <= 1'b0;
        cons_bank       <= ~cons_bank;
      end
    end
  end

  AST_DONE_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    prod_done |-> !full[prod_bank]); // R9
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_release && !cons_valid) |=> $stable(cons_bank)); // R10
endmodule

// File: rtl/pillar_feat_unit.sv
module pillar_feat_unit import pfu_pkg::*; #(
  parameter int COORD_W    = 16,
  parameter int MAX_PTS    = 16,
  parameter int GRID_W     = 7,
  parameter int CELL_SHIFT = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  output logic                          cmd_ready,
  input  logic [$clog2(MAX_PTS+1)-1:0]  cmd_count,
  input  logic [GRID_W-1:0]             cmd_gx,
  input  logic [GRID_W-1:0]             cmd_gy,
  output logic                          rd_en,
  output logic [$clog2(MAX_PTS)-1:0]    rd_addr,
  input  logic [4*COORD_W-1:0]          rd_data,
  output logic                          fb_we,
  output logic                          fb_bank,
  output logic [$clog2(MAX_PTS)-1:0]    fb_row,
  output logic [9*COORD_W-1:0]          fb_data,
  output logic                          cons_valid,
  output logic                          cons_bank,
  input  logic                          cons_release
);
  localparam int CNT_W = $clog2(MAX_PTS+1);
  localparam int IDX_W = $clog2(MAX_PTS);
  localparam int SUM_W = COORD_W + IDX_W;
  localparam int CTR_W = GRID_W + CELL_SHIFT;
  localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(MAX_PTS-1);

  pfu_state_e          state;
  logic [IDX_W-1:0]    idx;
  logic [CNT_W-1:0]    count_q;
  logic [GRID_W-1:0]   gx_q, gy_q;
  logic                acc_q, ofs_q, live_q;
  logic [IDX_W-1:0]    row_q;
  logic                prod_bank, prod_free, prod_done, accept, div_done;
  logic [NUM_AXES*SUM_W-1:0]   sums;
  logic [NUM_AXES*COORD_W-1:0] means;
  logic [CTR_W-1:0]    cx, cy;
  logic                idx_live;

  assign idx_live  = CNT_W'(idx) < count_q;
  assign cmd_ready = (state == ST_IDLE) && prod_free;
  assign accept    = cmd_valid && cmd_ready;
  assign rd_en     = (state == ST_ACC) || ((state == ST_OFS) && idx_live);
  assign rd_addr   = idx;
  assign prod_done = (state == ST_OFS_LAST);
  assign fb_we     = ofs_q;
  assign fb_row    = row_q;
  assign fb_bank   = prod_bank;
  assign cx = (CTR_W'(gx_q) << CELL_SHIFT) | CTR_W'(1 << (CELL_SHIFT-1));
  assign cy = (CTR_W'(gy_q) << CELL_SHIFT) | CTR_W'(1 << (CELL_SHIFT-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      count_q <= '0;
      gx_q    <= '0;
      gy_q    <= '0;
      acc_q   <= 1'b0;
      ofs_q   <= 1'b0;
      live_q  <= 1'b0;
      row_q   <= '0;
    end else begin
      acc_q  <= (state == ST_ACC);
      ofs_q  <= (state == ST_OFS);
      live_q <= (state == ST_OFS) && idx_live;
      row_q  <= idx;
      unique case (state)
        ST_IDLE: if (accept) begin
          count_q <= cmd_count;
          gx_q    <= cmd_gx;
          gy_q    <= cmd_gy;
          idx     <= '0;
          state   <= ST_ACC;
        end
        ST_ACC: begin
          if (CNT_W'(idx) == count_q - 1'b1) state <= ST_ACC_WAIT;
          else                               idx   <= idx + 1'b1;
        end
        ST_ACC_WAIT: begin
          idx   <= '0;
          state <= ST_DIV;
        end
        ST_DIV: if (div_done) state <= ST_OFS;
        ST_OFS: begin
          if (idx == LAST_ROW) state <= ST_OFS_LAST;
          else                 idx   <= idx + 1'b1;
        end
        ST_OFS_LAST: begin
          idx   <= '0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  pfu_accum #(.COORD_W(COORD_W), .SUM_W(SUM_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(acc_q),
    .xyz(rd_data[NUM_AXES*COORD_W-1:0]), .sums(sums)
  );

  pfu_mean_div #(.COORD_W(COORD_W), .MAX_PTS(MAX_PTS), .CNT_W(CNT_W),
                 .IDX_W(IDX_W), .SUM_W(SUM_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(state == ST_ACC_WAIT), .count(count_q),
    .sums(sums), .means(means), .done(div_done)
  );

  pfu_feat #(.COORD_W(COORD_W), .CTR_W(CTR_W)) u_feat (
    .live(live_q), .point(rd_data), .means(means), .cx(cx), .cy(cy),
    .feat(fb_data)
  );

  pfu_pingpong u_pp (
    .clk(clk), .rst_n(rst_n), .prod_done(prod_done), .cons_release(cons_release),
    .prod_bank(prod_bank), .prod_free(prod_free),
    .cons_bank(cons_bank), .cons_valid(cons_valid)
  );

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid); // R1
  AST_CMD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_count != '0 && cmd_count <= CNT_W'(MAX_PTS))); // R1
  AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (CNT_W'(rd_addr) < count_q)); // R2
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_we && $past(fb_we)) |-> (fb_row == IDX_W'($past(fb_row) + 1'b1))); // R7
  AST_WR_FREE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_we && cons_valid) |-> (fb_bank != cons_bank)); // R9
endmodule

// File: tb/sim_pillar_feat_unit.sv
module sim_pillar_feat_unit;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_PTS = 16;
  localparam int CNT_W = 5;
  localparam int IDX_W = 4;
  localparam int PT_W = 64;
  localparam int FEAT_W = 144;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [CNT_W-1:0] cmd_count = '0;
  logic [6:0] cmd_gx = '0, cmd_gy = '0;
  logic rd_en;
  logic [IDX_W-1:0] rd_addr;
  logic [PT_W-1:0] rd_data = '0;
  logic fb_we, fb_bank;
  logic [IDX_W-1:0] fb_row;
  logic [FEAT_W-1:0] fb_data;
  logic cons_valid, cons_bank;
  logic cons_release = 1'b0;

  pillar_feat_unit u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_count(cmd_count), .cmd_gx(cmd_gx), .cmd_gy(cmd_gy),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .fb_we(fb_we), .fb_bank(fb_bank), .fb_row(fb_row), .fb_data(fb_data),
    .cons_valid(cons_valid), .cons_bank(cons_bank), .cons_release(cons_release)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int px[MAX_PTS], py[MAX_PTS], pz[MAX_PTS], pr[MAX_PTS];
  logic [PT_W-1:0] pts[MAX_PTS];
  logic [FEAT_W-1:0] q_data[$];
  int q_row[$], q_bank[$];
  string q_tag[$];
  int pending = 0, exp_bank = 0, cur_count = 0, rd_seen = 0;

  // point store: one-cycle read latency
  always @(posedge clk) if (rd_en) rd_data <= pts[rd_addr];

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // monitor: scoreboard for feature writes, range check for reads
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      rd_seen++;
      chk(int'(rd_addr) < cur_count, "R2 read address", int'(rd_addr), cur_count - 1);
    end
    if (rst_n && fb_we) begin
      if (q_data.size() == 0) begin
        chk(1'b0, "R7 unexpected row write", int'(fb_row), -1);
      end else begin
        logic [FEAT_W-1:0] ed;
        int er, eb;
        string et;
        ed = q_data.pop_front(); er = q_row.pop_front();
        eb = q_bank.pop_front(); et = q_tag.pop_front();
        chk(int'(fb_bank) == eb, "R8 write bank", int'(fb_bank), eb);
        chk(int'(fb_row) == er, "R7 row order", int'(fb_row), er);
        checks++;
        if (fb_data !== ed) begin
          errors++;
          $display("FAIL %s row %0d: got %h expected %h", et, er, fb_data, ed);
        end
        pending--;
      end
    end
  end

  function automatic int rmean(input int s, input int n);
    int a, q;
    a = (s < 0) ? -s : s;
    q = (2*a + n) / (2*n);
    return (s < 0) ? -q : q;
  endfunction

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic run_pillar(input int n, input int gx, input int gy, input string tag);
    int sx, sy, sz, mx, my, mz, cx, cy;
    logic [FEAT_W-1:0] e;
    sx = 0; sy = 0; sz = 0;
    for (int i = 0; i < n; i++) begin
      sx += px[i]; sy += py[i]; sz += pz[i];
    end
    mx = rmean(sx, n); my = rmean(sy, n); mz = rmean(sz, n);
    cx = gx*32 + 16; cy = gy*32 + 16;
    for (int i = 0; i < MAX_PTS; i++)
      pts[i] = {16'(pr[i]), 16'(pz[i]), 16'(py[i]), 16'(px[i])};
    for (int row = 0; row < MAX_PTS; row++) begin
      e = '0;
      if (row < n) begin
        e[0*16 +: 16] = 16'(px[row]);
        e[1*16 +: 16] = 16'(py[row]);
        e[2*16 +: 16] = 16'(pz[row]);
        e[3*16 +: 16] = 16'(pr[row]);
        e[4*16 +: 16] = 16'(sat16(px[row] - mx));
        e[5*16 +: 16] = 16'(sat16(py[row] - my));
        e[6*16 +: 16] = 16'(sat16(pz[row] - mz));
        e[7*16 +: 16] = 16'(sat16(px[row] - cx));
        e[8*16 +: 16] = 16'(sat16(py[row] - cy));
      end
      q_data.push_back(e); q_row.push_back(row); q_bank.push_back(exp_bank);
      q_tag.push_back(row < n ? tag : "R7 zero row");
    end
    pending += MAX_PTS;
    cur_count = n; rd_seen = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_count = CNT_W'(n); cmd_gx = 7'(gx); cmd_gy = 7'(gy);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R1 ready low after accept", cmd_ready, 0);
    wait (pending == 0);
    @(negedge clk);
    chk(rd_seen == 2*n, "R2 read count", rd_seen, 2*n);
    exp_bank ^= 1;
  endtask

  task automatic release_bank();
    @(negedge clk) cons_release = 1'b1;
    @(negedge clk) cons_release = 1'b0;
  endtask

  task automatic clear_pts();
    for (int i = 0; i < MAX_PTS; i++) begin
      px[i] = 0; py[i] = 0; pz[i] = 0; pr[i] = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: cycles %0d expected below %0d", 100000, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_pts();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R11 cmd_ready", cmd_ready, 1);
    chk(cons_valid == 1'b0, "R11 cons_valid", cons_valid, 0);
    chk(cons_bank == 1'b0, "R11 cons_bank", cons_bank, 0);
    chk(rd_en == 1'b0, "R11 rd_en", rd_en, 0);
    chk(fb_we == 1'b0, "R11 fb_we", fb_we, 0);

    // R10: release with nothing held
    release_bank();
    chk(cons_bank == 1'b0, "R10 bank after idle release", cons_bank, 0);
    chk(cons_valid == 1'b0, "R10 valid after idle release", cons_valid, 0);
    chk(cmd_ready == 1'b1, "R10 ready after idle release", cmd_ready, 1);

    // R3: single point
    px[0] = 100; py[0] = -50; pz[0] = 7; pr[0] = 3;
    run_pillar(1, 3, 5, "R3 single point");
    chk(cons_valid == 1'b1, "R8 valid after first pillar", cons_valid, 1);
    chk(cons_bank == 1'b0, "R8 first pillar in bank 0", cons_bank, 0);

    // R4: ties away from zero, goes to bank 1
    clear_pts();
    px[0] = -1; px[1] = 0; py[0] = 1; py[1] = 0;
    pz[0] = 3;  pz[1] = 4; pr[0] = 9; pr[1] = 9;
    run_pillar(2, 0, 0, "R4 tie rounding");
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b0, "R9 stall while bank 0 held", cmd_ready, 0);
    chk(rd_en == 1'b0, "R9 no reads while stalled", rd_en, 0);
    release_bank();
    chk(cons_bank == 1'b1, "R8 consumer moves to bank 1", cons_bank, 1);
    chk(cons_valid == 1'b1, "R8 bank 1 complete", cons_valid, 1);
    chk(cmd_ready == 1'b1, "R9 ready after release", cmd_ready, 1);
    release_bank();
    chk(cons_bank == 1'b0, "R8 consumer back to bank 0", cons_bank, 0);
    chk(cons_valid == 1'b0, "R8 nothing held", cons_valid, 0);

    // R6: saturation of differences
    clear_pts();
    px[0] = 32767; px[1] = -32768; py[0] = -32768; py[1] = -32768;
    run_pillar(2, 127, 0, "R6 saturation");
    release_bank();

    // R5: center offsets
    clear_pts();
    px[0] = 340; py[0] = 650; px[1] = 320; py[1] = 641; px[2] = 335; py[2] = 660;
    pz[0] = -5; pz[1] = 6; pz[2] = 2;
    run_pillar(3, 10, 20, "R5 center offset");
    release_bank();

    // R4: full pillar with mixed signs
    for (int i = 0; i < MAX_PTS; i++) begin
      px[i] = (i % 2 == 0) ? -1000 - 37*i : 900 + 11*i;
      py[i] = -20000 + 2500*i; pz[i] = 5 - 3*i; pr[i] = i*7;
    end
    run_pillar(16, 64, 33, "R4 full pillar");
    release_bank();

    // R3: varied pillars
    for (int k = 0; k < 12; k++) begin
      int n;
      clear_pts();
      n = 1 + int'($urandom_range(15));
      for (int i = 0; i < n; i++) begin
        px[i] = int'($urandom_range(65535)) - 32768;
        py[i] = int'($urandom_range(65535)) - 32768;
        pz[i] = int'($urandom_range(65535)) - 32768;
        pr[i] = int'($urandom_range(65535)) - 32768;
      end
      run_pillar(n, int'($urandom_range(127)), int'($urandom_range(127)), "R3 varied pillar");
      release_bank();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule